// File: doc/BRIEF.md
# Machine cycle timing sequencer

This block paces a small 8-bit processor. It splits time into machine cycles of eight clocks each. In every cycle it raises two strobes, first an early one and then a late one. It selects which half of the multiplexed address goes out, and it reports the kind of cycle now running. That kind is one of four: an opcode fetch, an execute step, a direct memory transfer, or an interrupt entry. The decode logic sends a few hints. These say whether a prefix byte needs another fetch, whether the instruction needs another execute step, and whether the instruction is the idle one. From these hints and from the request lines, the sequencer picks the kind of the next cycle at the end of each cycle.

Two active-low control lines govern the block. A low clear line resets it at once, whatever the wait line shows. A low wait line with clear high requests a pause. When reset ends, the block runs one initialization cycle of nine clocks and then enters normal operation. The pause stops the count only while one of the two strobes is high. The idle instruction parks the sequencer on the late strobe until a transfer or interrupt request arrives.

Top module: `mcyc_seq`

## Requirements
- R1: A normal cycle lasts exactly 8 clocks, with the count output running 0 to 7. The early strobe `tpa` is high only at count 1 and the late strobe `tpb` only at count 6, and the two are never high together.
- R2: `addr_hi` is 1 during counts 0 and 1 and during the first half-clock of count 2. It is 0 from the falling clock edge inside count 2 until the cycle wraps.
- R3: With `clear_n` low the block is in reset asynchronously, for either level of `wait_n`: count 0, state code 01, both strobes low, `addr_hi` 1, `in_init` 1. After release, the initialization cycle lasts 9 clocks (count 0 to 8) with state code 01. An interrupt request is never sampled in it. The next cycle is a transfer (state code 10) if a transfer request was high at its late strobe, and a fetch (00) otherwise.
- R4: State codes are 00 fetch, 01 execute, 10 transfer and 11 interrupt. They change only when the count wraps to 0. A fetch is followed by an execute, unless `prefix_hint` is high at the end of the fetch, in which case another fetch follows.
- R5: If `exec_more` is high at the end of an execute cycle, another execute cycle follows and no pending request is serviced yet.
- R6: Transfer requests are sampled at the late strobe of execute, transfer and interrupt cycles. At the end of a last execute cycle, or of a transfer cycle, a sampled transfer-in wins over transfer-out, which wins over an interrupt. `dma_is_out` is 1 during a transfer cycle started for transfer-out and 0 for transfer-in.
- R7: The interrupt request is sampled only at the late strobe of execute and transfer cycles. An interrupt cycle with no transfer request at its late strobe is followed by a fetch, even if the interrupt line is still high.
- R8: With `wait_n` low and `clear_n` high, the count holds while `tpa` or `tpb` is high, and the strobe stays high. A pause raised at another count lets the count run on to the next strobe and hold there. When `wait_n` returns high, counting resumes at the next clock.
- R9: An execute cycle (not the initialization cycle) with `idle_hint` high at the late strobe holds at count 6 with `idle` at 1 while no request is present. A transfer or interrupt request ends the hold, and that request is serviced in the next cycle.
- R10: A fetch cycle samples no request. A transfer request during a fetch does not change the next cycle from execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clear_n | input | 1 | Active-low clear, asynchronous reset |
| wait_n | input | 1 | Active-low wait, pause request |
| dma_in_req | input | 1 | Transfer-in request |
| dma_out_req | input | 1 | Transfer-out request |
| int_req | input | 1 | Interrupt request, already gated by the enables |
| prefix_hint | input | 1 | Decode hint: fetched byte is a prefix |
| exec_more | input | 1 | Decode hint: another execute cycle is needed |
| idle_hint | input | 1 | Decode hint: the current instruction is idle |
| cnt | output | CNT_W | Clock count within the cycle |
| tpa | output | 1 | Early timing strobe |
| tpb | output | 1 | Late timing strobe |
| addr_hi | output | 1 | 1 selects the high address byte |
| state_code | output | 2 | Kind of the current cycle |
| next_code | output | 2 | Kind chosen for the next cycle, valid at the last count |
| dma_is_out | output | 1 | Direction of the running transfer cycle |
| in_init | output | 1 | Initialization cycle in progress |
| idle | output | 1 | Parked by the idle instruction |

## Verification
Most faults in the counter or the cycle-kind register show at the ports within one cycle of eight clocks. A wrong wrap point or a shifted strobe moves `tpa`, `tpb` or `addr_hi` away from their counts. A wrong choice of next cycle shows on `state_code` at the first clock of the following cycle. Faults in the request latches stay hidden until a cycle kind that reads them ends. They then show as the wrong cycle kind or transfer direction one cycle later, so the bench runs long sequences of cycle kinds and not single cycles.

// File: rtl/mcyc_seq.sv
module mcyc_seq #(
  parameter int CYC_LEN = 8,
  parameter int TPA_AT  = 1,
  parameter int TPB_AT  = 6,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             wait_n,
  input  logic             dma_in_req,
  input  logic             dma_out_req,
  input  logic             int_req,
  input  logic             prefix_hint,
  input  logic             exec_more,
  input  logic             idle_hint,
  output logic [CNT_W-1:0] cnt,
  output logic             tpa,
  output logic             tpb,
  output logic             addr_hi,
  output logic [1:0]       state_code,
  output logic [1:0]       next_code,
  output logic             dma_is_out,
  output logic             in_init,
  output logic             idle
);

  localparam logic [1:0] SC_F = 2'b00;
  localparam logic [1:0] SC_E = 2'b01;
  localparam logic [1:0] SC_D = 2'b10;
  localparam logic [1:0] SC_I = 2'b11;
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(CYC_LEN - 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(CYC_LEN);
  localparam logic [CNT_W-1:0] A_POS     = CNT_W'(TPA_AT);
  localparam logic [CNT_W-1:0] B_POS     = CNT_W'(TPB_AT);
  localparam logic [CNT_W-1:0] LO_POS    = CNT_W'(TPA_AT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       sc_q;
  logic             init_q, idle_q, din_q, dout_q, irq_q, dir_q, lo_q;

  wire at_a      = (cnt_q == A_POS);
  wire at_b      = (cnt_q == B_POS);
  wire at_last   = init_q ? (cnt_q == INIT_LAST) : (cnt_q == LAST);
  wire any_dma   = din_q | dout_q;
  wire wake      = dma_in_req | dma_out_req | int_req;
  wire pause_hld = ~wait_n & (at_a | at_b);
  wire idle_cand = (sc_q == SC_E) & ~init_q & at_b & (idle_hint | idle_q);
  wire idle_hld  = idle_cand & ~wake;
  wire hold      = pause_hld | idle_hld;
  wire samp_dma  = at_b & (sc_q != SC_F);
  wire samp_irq  = at_b & ~init_q & ((sc_q == SC_E) | (sc_q == SC_D));

  always_comb begin
    next_code = SC_F;
    case (sc_q)
      SC_F: next_code = prefix_hint ? SC_F : SC_E;
      SC_E: begin
        if (init_q)         next_code = any_dma ? SC_D : SC_F;
        else if (exec_more) next_code = SC_E;
        else if (any_dma)   next_code = SC_D;
        else if (irq_q)     next_code = SC_I;
        else                next_code = SC_F;
      end
      SC_D: begin
        if (any_dma)    next_code = SC_D;
        else if (irq_q) next_code = SC_I;
        else            next_code = SC_F;
      end
      SC_I: next_code = any_dma ? SC_D : SC_F;
      default: next_code = SC_F;
    endcase
  end

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      cnt_q  <= '0;
      sc_q   <= SC_E;
      init_q <= 1'b1;
      idle_q <= 1'b0;
      din_q  <= 1'b0;
      dout_q <= 1'b0;
      irq_q  <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      if (samp_dma) begin
        din_q  <= dma_in_req;
        dout_q <= dma_out_req;
      end
      if (samp_irq) irq_q <= int_req;
      idle_q <= idle_hld;
      if (!hold) begin
        if (at_last) begin
          cnt_q  <= '0;
          sc_q   <= next_code;
          init_q <= 1'b0;
          dir_q  <= (next_code == SC_D) & ~din_q & dout_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(negedge clk or negedge clear_n) begin
    if (!clear_n) lo_q <= 1'b0;
    else          lo_q <= (cnt_q >= LO_POS);
  end

  assign cnt        = cnt_q;
  assign tpa        = at_a;
  assign tpb        = at_b;
  assign addr_hi    = ~lo_q | (cnt_q <= A_POS);
  assign state_code = sc_q;
  assign dma_is_out = dir_q;
  assign in_init    = init_q;
  assign idle       = idle_q;

endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk #(
  parameter int CYC_LEN = 8,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             clear_n,
  input logic             wait_n,
  input logic [CNT_W-1:0] cnt,
  input logic             tpa,
  input logic             tpb,
  input logic             addr_hi,
  input logic [1:0]       state_code,
  input logic             in_init,
  input logic             idle
);

  localparam logic [CNT_W-1:0] LAST      = CNT_W'(CYC_LEN - 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(CYC_LEN);

  p_pulse_excl_r1: assert property (@(posedge clk) disable iff (!clear_n)
    $onehot0({tpa, tpb}));

  p_count_range_r1: assert property (@(posedge clk) disable iff (!clear_n)
    !in_init |-> (cnt <= LAST));

  p_addr_hi_early_r2: assert property (@(posedge clk) disable iff (!clear_n)
    (cnt < CNT_W'(2)) |-> addr_hi);

  p_addr_lo_late_r2: assert property (@(posedge clk) disable iff (!clear_n)
    (cnt >= CNT_W'(3) && cnt <= LAST) |-> !addr_hi);

  p_init_exit_r3: assert property (@(posedge clk) disable iff (!clear_n)
    (in_init && cnt == INIT_LAST) |=> (state_code == 2'b00 || state_code == 2'b10));

  p_code_stable_r4: assert property (@(posedge clk) disable iff (!clear_n)
    (cnt != LAST && cnt != INIT_LAST) |=> $stable(state_code));

  p_pause_hold_r8: assert property (@(posedge clk) disable iff (!clear_n)
    (!wait_n && (tpa || tpb)) |=> $stable(cnt));

  p_idle_park_r9: assert property (@(posedge clk) disable iff (!clear_n)
    idle |-> (tpb && state_code == 2'b01));

endmodule

bind mcyc_seq mcyc_seq_chk #(.CYC_LEN(CYC_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .clear_n(clear_n), .wait_n(wait_n), .cnt(cnt), .tpa(tpa),
  .tpb(tpb), .addr_hi(addr_hi), .state_code(state_code), .in_init(in_init),
  .idle(idle)
);

// File: tb/sim_mcyc_seq.sv
`timescale 1ns/1ps
module sim_mcyc_seq;
  logic clk = 1'b0;
  logic clear_n = 1'b0, wait_n = 1'b1;
  logic din = 1'b0, dout = 1'b0, irq = 1'b0, prefix = 1'b0, more = 1'b0, idl = 1'b0;
  logic [3:0] cnt;
  logic tpa, tpb, addr_hi, dir, in_init, idle;
  logic [1:0] sc, nc;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mcyc_seq u0 (
    .clk(clk), .clear_n(clear_n), .wait_n(wait_n), .dma_in_req(din),
    .dma_out_req(dout), .int_req(irq), .prefix_hint(prefix), .exec_more(more),
    .idle_hint(idl), .cnt(cnt), .tpa(tpa), .tpb(tpb), .addr_hi(addr_hi),
    .state_code(sc), .next_code(nc), .dma_is_out(dir), .in_init(in_init),
    .idle(idle)
  );

  // row bits: {code[1:0], dir, prefix, more, din, dout, irq}
  localparam int NROW = 18;
  localparam logic [7:0] TBL [NROW] = '{
    8'b01_0_00000,  // E none -> F
    8'b00_0_00000,  // F -> E (R4)
    8'b01_0_01000,  // E more -> E (R5)
    8'b01_0_00000,  // E none -> F
    8'b00_0_10000,  // F prefix -> F (R4)
    8'b00_0_00100,  // F din ignored -> E (R10)
    8'b01_0_00110,  // E din+dout -> D in (R6)
    8'b10_0_00010,  // D dout -> D out (R6)
    8'b10_1_00001,  // D irq -> I (R6)
    8'b11_0_00001,  // I irq not sampled -> F (R7)
    8'b00_0_00000,  // F -> E
    8'b01_0_00001,  // E irq -> I
    8'b11_0_00100,  // I din -> D
    8'b10_0_00000,  // D none -> F
    8'b00_0_00000,  // F -> E
    8'b01_0_01100,  // E more+din -> E, not serviced (R5)
    8'b01_0_00000,  // E none -> F
    8'b00_0_00000   // F -> E
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_reset(input string tag);
    chk(cnt == 0, {tag, " cnt"}, cnt, 0);
    chk(sc == 2'b01, {tag, " code"}, sc, 1);
    chk(!tpa && !tpb, {tag, " strobes"}, {tpa, tpb}, 0);
    chk(addr_hi, {tag, " addr_hi"}, addr_hi, 1);
    chk(in_init, {tag, " in_init"}, in_init, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_reset("R3 reset clear low");
    wait_n = 1'b0;
    repeat (2) @(negedge clk);
    chk_reset("R3 reset both low");
    wait_n = 1'b1;
    irq = 1'b1;
    clear_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(cnt == 8, "R3 init count reaches 8", cnt, 8);
    chk(sc == 2'b01 && in_init, "R3 init code", sc, 1);
    @(negedge clk);
    chk(cnt == 0 && sc == 2'b00, "R3 init then fetch despite irq", sc, 0);
    chk(!in_init, "R3 init ends", in_init, 0);
    irq = 1'b0;

    for (int k = 1; k < 8; k++) begin
      @(posedge clk); #1;
      chk(cnt == k, "R1 count step", cnt, k);
      chk(tpa == (k == 1), "R1 tpa position", tpa, k == 1);
      chk(tpb == (k == 6), "R1 tpb position", tpb, k == 6);
      if (k == 1) chk(addr_hi, "R2 high byte at count 1", addr_hi, 1);
      if (k == 2) begin
        chk(addr_hi, "R2 high byte first half of count 2", addr_hi, 1);
        @(negedge clk); #1;
        chk(!addr_hi, "R2 low byte after falling edge", addr_hi, 0);
      end
    end
    @(posedge clk); #1;
    chk(cnt == 0 && sc == 2'b01, "R1 eight-clock cycle, R4 fetch to execute", sc, 1);
    chk(addr_hi, "R2 high byte at wrap", addr_hi, 1);

    @(negedge clk);
    for (int i = 0; i < NROW; i++) begin
      logic [7:0] r;
      r = TBL[i];
      prefix = r[4]; more = r[3]; din = r[2]; dout = r[1]; irq = r[0];
      chk(sc == r[7:6], $sformatf("table row %0d code (R4 R5 R6 R7 R10)", i), sc, r[7:6]);
      if (r[7:6] == 2'b10)
        chk(dir == r[5], $sformatf("table row %0d direction R6", i), dir, r[5]);
      repeat (8) @(negedge clk);
    end
    prefix = 0; more = 0; din = 0; dout = 0; irq = 0;

    chk(sc == 2'b01 && cnt == 0, "R4 table end in execute", sc, 1);
    wait_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(cnt == 1 && tpa, "R8 pause holds at tpa", cnt, 1);
    wait_n = 1'b1;
    @(negedge clk);
    chk(cnt == 2, "R8 resume after tpa", cnt, 2);
    @(negedge clk);
    wait_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(cnt == 6 && tpb, "R8 pause runs to tpb and holds", cnt, 6);
    wait_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(cnt == 0 && sc == 2'b00, "R8 cycle completes after pause", sc, 0);

    repeat (8) @(negedge clk);
    chk(sc == 2'b01, "R9 in execute before idle", sc, 1);
    idl = 1'b1;
    repeat (20) @(negedge clk);
    chk(cnt == 6 && tpb && sc == 2'b01, "R9 idle parks at tpb", cnt, 6);
    chk(idle, "R9 idle flag", idle, 1);
    idl = 1'b0;
    dout = 1'b1;
    repeat (2) @(negedge clk);
    chk(sc == 2'b10 && cnt == 0, "R9 wake into transfer", sc, 2);
    chk(dir && !idle, "R9 wake transfer out, idle cleared", {dir, idle}, 2);
    dout = 1'b0;

    clear_n = 1'b0;
    din = 1'b1;
    @(negedge clk);
    chk_reset("R3 second reset");
    clear_n = 1'b1;
    repeat (9) @(negedge clk);
    chk(sc == 2'b10 && cnt == 0, "R3 init then transfer", sc, 2);
    chk(!dir, "R3 transfer-in after init", dir, 0);
    din = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule